// File: doc/BRIEF.md
# Serial Line Core with Character Format Control and Loopback

This block is a serial transmit and receive engine. A small line-control register picks the character width (5, 6, 7 or 8 data bits) and the stop length. A modem-control register drives four general modem outputs and holds a self-test switch. Bit timing comes from an external strobe, `baud_tick`, that pulses once per sixteenth of a bit. The baud divisor that makes this strobe is outside the block.

A parent writes bytes through a valid/ready port. The transmitter sends a low start bit, then the data bits least significant first, then the stop time. The receiver watches the line at sixteen samples per bit and confirms a start at mid-bit. It samples each data bit at its centre and then checks the first stop bit. It reports each character on a one-cycle strobe together with a framing flag.

When the self-test switch is on, the transmit stream feeds the receiver inside the block and the `txd` pin rests at 1. The four modem status lines then read back the four modem outputs instead of the external pins. Software can check the whole data path and the status path without any wiring outside the block.

Top module: `uart_line_core`

## Requirements
- R1: The line-control width field `lcr_rd[1:0]` picks 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. A character is sent as a low start bit lasting 16 baud ticks, then the data bits LSB first, 16 ticks each. The line goes low on the cycle after the transmit handshake.
- R2: With the stop control `lcr_rd[2]` at 0, the line is high for 16 ticks after the last data bit, and then the transmitter is ready again.
- R3: With `lcr_rd[2]` at 1, the stop time is 24 ticks for 5-bit characters and 32 ticks for 6- to 8-bit characters.
- R4: The receiver confirms a start at the 8th tick after it sees a low line and samples each data bit 16 ticks later than the one before. It presents the bits right-aligned on `rx_data`, with the unused upper bits at 0, and `rx_valid` high for exactly one clock.
- R5: The receiver checks only the first stop bit, whatever the stop setting. A frame that follows after a single stop bit is received correctly even while `lcr_rd[2]` is 1.
- R6: If the first stop bit samples low, `rx_frame_err` is raised together with `rx_valid` and the data. No new start is then looked for until the line has been seen high.
- R7: With the self-test bit `mcr_rd[4]` set, the transmit stream reaches the receiver internally and every character sent is received. The `rxd` pin is ignored and `txd` stays at 1.
- R8: `dtr`, `rts`, `out1` and `out2` follow `mcr_rd[0..3]`. With `mcr_rd[4]` set, `dsr_st`, `cts_st`, `ri_st` and `dcd_st` equal `dtr`, `rts`, `out1` and `out2`. Otherwise they follow the `dsr`, `cts`, `ri` and `dcd` pins.
- R9: Writes use `cfg_addr` 0 for line control and 1 for modem control. Read-back bits 7:3 of line control and bits 7:5 of modem control are always 0.
- R10: A line-control write made while a character is in flight does not change that character. The new setting applies from the next character.
- R11: `tx_ready` is high only while the transmitter is idle. A byte is taken on a clock where `tx_valid` and `tx_ready` are both high.
- R12: After reset, `txd` is 1, `tx_ready` is 1, `rx_valid` is 0 and both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 1 | 0 selects line control, 1 selects modem control |
| cfg_wdata | input | 8 | Register write data |
| lcr_rd | output | 8 | Line-control read-back |
| mcr_rd | output | 8 | Modem-control read-back |
| tx_data | input | 8 | Byte to send, right-aligned |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter idle and able to take a byte |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_frame_err | output | 1 | First stop bit was low, qualified by rx_valid |
| txd | output | 1 | Serial output pin |
| rxd | input | 1 | Serial input pin |
| dtr | output | 1 | Modem output 0 |
| rts | output | 1 | Modem output 1 |
| out1 | output | 1 | Modem output 2 |
| out2 | output | 1 | Modem output 3 |
| dsr | input | 1 | Modem input pin paired with dtr |
| cts | input | 1 | Modem input pin paired with rts |
| ri | input | 1 | Modem input pin paired with out1 |
| dcd | input | 1 | Modem input pin paired with out2 |
| dsr_st | output | 1 | Effective dsr status |
| cts_st | output | 1 | Effective cts status |
| ri_st | output | 1 | Effective ri status |
| dcd_st | output | 1 | Effective dcd status |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse with at least one idle clock between pulses. They also assume that `rxd` changes only at whole-tick boundaries, so that a mid-bit sample never lands on an edge. The stimulus makes `baud_tick` one clock in every four and drives external frames in whole ticks of sixteen per bit. It also returns `rxd` to high before the self-test switch is turned off, so that switching paths never shows the receiver a false start edge.

// File: rtl/uart_line_pkg.sv
package uart_line_pkg;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  // line control: bit 2 long stop, bits 1:0 width code
  typedef struct packed {
    logic       stop2;
    logic [1:0] len;
  } line_cfg_t;

  // modem control: bit 4 self-test, bits 3:0 modem outputs
  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } modem_cfg_t;

endpackage

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_line_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       addr,
  input  logic [7:0] wdata,
  output line_cfg_t  line_o,
  output modem_cfg_t modem_o,
  output logic [7:0] lcr_rd,
  output logic [7:0] mcr_rd
);

  line_cfg_t  line_q, line_d;
  modem_cfg_t modem_q, modem_d;
  logic       unused_hi;

  assign unused_hi = ^wdata[7:5];

  always_comb begin
    line_d  = line_q;
    modem_d = modem_q;
    if (we) begin
      if (!addr) line_d  = line_cfg_t'(wdata[2:0]);
      else       modem_d = modem_cfg_t'(wdata[4:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      modem_q <= '0;
    end else begin
      line_q  <= line_d;
      modem_q <= modem_d;
    end
  end

  assign line_o  = line_q;
  assign modem_o = modem_q;
  assign lcr_rd  = {5'b0, line_q};
  assign mcr_rd  = {3'b0, modem_q};

endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_line_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  line_cfg_t     cfg,
  input  logic [DW-1:0] data,
  input  logic          valid,
  output logic          ready,
  output logic          ser_o
);

  localparam int CW = $clog2(2 * OVS);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] BIT_END  = CW'(OVS - 1);
  localparam logic [CW-1:0] STOP_1   = CW'(OVS - 1);
  localparam logic [CW-1:0] STOP_1H  = CW'(OVS + OVS / 2 - 1);
  localparam logic [CW-1:0] STOP_2   = CW'(2 * OVS - 1);

  tx_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic [DW-1:0]  sh_q, sh_d;
  line_cfg_t      cfg_q, cfg_d;
  logic           ser_q, ser_d;
  logic [IW-1:0]  last_idx;
  logic [CW-1:0]  stop_end;

  // format is taken from the register copy latched at the handshake
  always_comb begin
    last_idx = IW'(4 + cfg_q.len);
    if (!cfg_q.stop2)          stop_end = STOP_1;
    else if (cfg_q.len == 2'd0) stop_end = STOP_1H;
    else                        stop_end = STOP_2;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    cfg_d = cfg_q;
    ser_d = ser_q;
    case (st_q)
      TX_IDLE: begin
        ser_d = 1'b1;
        if (valid) begin
          st_d  = TX_START;
          cfg_d = cfg;
          sh_d  = data;
          cnt_d = '0;
          idx_d = '0;
          ser_d = 1'b0;
        end
      end
      TX_START: begin
        if (tick) begin
          if (cnt_q == BIT_END) begin
            cnt_d = '0;
            st_d  = TX_DATA;
            ser_d = sh_q[0];
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      TX_DATA: begin
        if (tick) begin
          if (cnt_q == BIT_END) begin
            cnt_d = '0;
            if (idx_q == last_idx) begin
              st_d  = TX_STOP;
              ser_d = 1'b1;
            end else begin
              idx_d = idx_q + 1'b1;
              sh_d  = sh_q >> 1;
              ser_d = sh_q[1];
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      TX_STOP: begin
        if (tick) begin
          if (cnt_q == stop_end) begin
            st_d  = TX_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      cfg_q <= '0;
      ser_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      cfg_q <= cfg_d;
      ser_q <= ser_d;
    end
  end

  assign ready = (st_q == TX_IDLE);
  assign ser_o = ser_q;

  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> !ser_o);

  assert_single_stop_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_STOP && !cfg_q.stop2) |-> (cnt_q < CW'(OVS)));

endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_line_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_in,
  input  logic [1:0]    len,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          ferr_o
);

  localparam int CW = $clog2(2 * OVS);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] MID_END = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] BIT_END = CW'(OVS - 1);

  rx_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic [DW-1:0]  sh_q, sh_d;
  logic [1:0]     len_q, len_d;
  logic [DW-1:0]  data_q, data_d;
  logic           valid_q, valid_d;
  logic           ferr_q, ferr_d;
  logic [IW-1:0]  last_idx;

  assign last_idx = IW'(4 + len_q);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    len_d   = len_q;
    data_d  = data_q;
    ferr_d  = ferr_q;
    valid_d = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (tick && !rx_in) begin
          st_d  = RX_START;
          cnt_d = '0;
          idx_d = '0;
          sh_d  = '0;
          len_d = len;
        end
      end
      RX_START: begin
        if (tick) begin
          if (cnt_q == MID_END) begin
            cnt_d = '0;
            st_d  = rx_in ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (cnt_q == BIT_END) begin
            cnt_d       = '0;
            sh_d[idx_q] = rx_in;
            if (idx_q == last_idx) st_d = RX_STOP;
            else                   idx_d = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (cnt_q == BIT_END) begin
            cnt_d   = '0;
            valid_d = 1'b1;
            data_d  = sh_q;
            ferr_d  = !rx_in;
            st_d    = rx_in ? RX_IDLE : RX_HOLD;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_HOLD: begin
        if (tick && rx_in) st_d = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      len_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      len_q   <= len_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign ferr_o  = ferr_q;

  assert_strobe_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_hold_until_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_HOLD && !rx_in) |=> (st_q == RX_HOLD));

endmodule

// File: rtl/uart_line_core.sv
module uart_line_core
  import uart_line_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    lcr_rd,
  output logic [7:0]    mcr_rd,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_frame_err,
  output logic          txd,
  input  logic          rxd,
  output logic          dtr,
  output logic          rts,
  output logic          out1,
  output logic          out2,
  input  logic          dsr,
  input  logic          cts,
  input  logic          ri,
  input  logic          dcd,
  output logic          dsr_st,
  output logic          cts_st,
  output logic          ri_st,
  output logic          dcd_st
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic [1:0] rxd_sync_q;
  logic       tx_ser;
  logic       rx_path;
  line_cfg_t  line_cfg;
  modem_cfg_t modem_cfg;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rxd_sync_q <= 2'b11;
    else            rxd_sync_q <= {rxd_sync_q[0], rxd};
  end

  uart_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .line_o  (line_cfg),
    .modem_o (modem_cfg),
    .lcr_rd  (lcr_rd),
    .mcr_rd  (mcr_rd)
  );

  uart_tx #(.OVS(OVS), .DW(DW)) u_tx (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (baud_tick),
    .cfg   (line_cfg),
    .data  (tx_data),
    .valid (tx_valid),
    .ready (tx_ready),
    .ser_o (tx_ser)
  );

  assign rx_path = modem_cfg.loop ? tx_ser : rxd_sync_q[1];

  uart_rx #(.OVS(OVS), .DW(DW)) u_rx (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (baud_tick),
    .rx_in   (rx_path),
    .len     (line_cfg.len),
    .data_o  (rx_data),
    .valid_o (rx_valid),
    .ferr_o  (rx_frame_err)
  );

  assign txd  = modem_cfg.loop ? 1'b1 : tx_ser;
  assign dtr  = modem_cfg.dtr;
  assign rts  = modem_cfg.rts;
  assign out1 = modem_cfg.out1;
  assign out2 = modem_cfg.out2;

  always_comb begin
    if (modem_cfg.loop) begin
      dsr_st = modem_cfg.dtr;
      cts_st = modem_cfg.rts;
      ri_st  = modem_cfg.out1;
      dcd_st = modem_cfg.out2;
    end else begin
      dsr_st = dsr;
      cts_st = cts;
      ri_st  = ri;
      dcd_st = dcd;
    end
  end

  assert_pin_idle_in_test_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    mcr_rd[4] |-> txd);

  assert_status_crossed_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    mcr_rd[4] |-> (dsr_st == dtr && cts_st == rts && ri_st == out1 && dcd_st == out2));

endmodule

// File: tb/uart_line_core_test.sv
module uart_line_core_test;

  logic       clk, rst_n, baud_tick;
  logic       cfg_we, cfg_addr;
  logic [7:0] cfg_wdata, lcr_rd, mcr_rd;
  logic [7:0] tx_data, rx_data;
  logic       tx_valid, tx_ready, rx_valid, rx_frame_err;
  logic       txd, rxd;
  logic       dtr, rts, out1, out2, dsr, cts, ri, dcd;
  logic       dsr_st, cts_st, ri_st, dcd_st;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R12";

  uart_line_core uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .lcr_rd(lcr_rd), .mcr_rd(mcr_rd),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .txd(txd), .rxd(rxd),
    .dtr(dtr), .rts(rts), .out1(out1), .out2(out2),
    .dsr(dsr), .cts(cts), .ri(ri), .dcd(dcd),
    .dsr_st(dsr_st), .cts_st(cts_st), .ri_st(ri_st), .dcd_st(dcd_st)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // one tick in every four clocks
  initial begin
    baud_tick = 1'b0;
    forever begin
      repeat (3) @(posedge clk);
      #2 baud_tick = 1'b1;
      @(posedge clk);
      #2 baud_tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string t, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit  model_on = 0;
  int  run_cnt[$];
  bit  run_lvl[$];
  int  exp_data[$];
  bit  exp_err[$];
  bit  m_ser = 1;
  int  m_len = 0;
  bit  m_stop = 0;
  bit  m_loop = 0;
  bit  p_tick = 0, p_acc = 0, p_we = 0, p_addr = 0;
  int  p_wd = 0, p_txd = 0;

  function automatic int nbits(input int code);
    return 5 + code;
  endfunction

  function automatic int stop_ticks(input int code, input bit st);
    if (!st) return 16;
    return (code == 0) ? 24 : 32;
  endfunction

  always @(negedge clk) begin
    if (model_on) begin
      if (p_acc) begin
        run_cnt.push_back(16); run_lvl.push_back(1'b0);
        for (int i = 0; i < nbits(m_len); i++) begin
          run_cnt.push_back(16); run_lvl.push_back(p_txd[i]);
        end
        run_cnt.push_back(stop_ticks(m_len, m_stop)); run_lvl.push_back(1'b1);
        if (m_loop) begin
          exp_data.push_back(p_txd & ((1 << nbits(m_len)) - 1));
          exp_err.push_back(1'b0);
        end
        m_ser = 1'b0;
      end else if (p_tick && run_cnt.size() > 0) begin
        run_cnt[0]--;
        if (run_cnt[0] == 0) begin
          void'(run_cnt.pop_front());
          void'(run_lvl.pop_front());
        end
        m_ser = (run_cnt.size() > 0) ? run_lvl[0] : 1'b1;
      end
      if (p_we) begin
        if (!p_addr) begin m_len = p_wd & 3; m_stop = p_wd[2]; end
        else m_loop = p_wd[4];
      end
      // R1 R2 R3 R7 R10: serial pin every clock; R11: ready every clock
      check(txd === (m_loop ? 1'b1 : m_ser), {tag, " txd"}, txd, m_loop ? 1 : m_ser);
      check(tx_ready === (run_cnt.size() == 0), "R11 tx_ready", tx_ready, run_cnt.size() == 0);
      if (rx_valid) begin
        if (exp_data.size() == 0) begin
          check(1'b0, "R4 R6 R7 unexpected character", rx_data, -1);
        end else begin
          check(rx_data === 8'(exp_data[0]), {tag, " rx_data"}, rx_data, exp_data[0]);
          check(rx_frame_err === exp_err[0], {tag, " rx_frame_err"}, rx_frame_err, exp_err[0]);
          void'(exp_data.pop_front());
          void'(exp_err.pop_front());
        end
      end
    end
    p_tick = baud_tick;
    p_acc  = tx_valid && tx_ready;
    p_txd  = tx_data;
    p_we   = cfg_we;
    p_addr = cfg_addr;
    p_wd   = cfg_wdata;
  end

  // ---------------- stimulus tasks ----------------
  task automatic write_reg(input bit a, input logic [7:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    bit acc;
    @(posedge clk); #2;
    tx_valid = 1'b1; tx_data = d;
    do begin
      @(negedge clk); acc = tx_ready;
      @(posedge clk);
    end while (!acc);
    #2 tx_valid = 1'b0;
  endtask

  task automatic wait_tx_idle();
    do @(negedge clk); while (!tx_ready);
  endtask

  task automatic hold_rx(input bit lvl, input int ticks);
    rxd = lvl;
    repeat (4 * ticks) @(posedge clk);
    #2;
  endtask

  task automatic drive_frame(input logic [7:0] d, input int nb, input bit stop_lvl);
    exp_data.push_back(d & ((1 << nb) - 1));
    exp_err.push_back(!stop_lvl);
    @(posedge clk); #2;
    hold_rx(1'b0, 16);
    for (int i = 0; i < nb; i++) hold_rx(d[i], 16);
    hold_rx(stop_lvl, 16);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
    tx_valid = 1'b0; tx_data = '0; rxd = 1'b1;
    dsr = 1'b0; cts = 1'b0; ri = 1'b0; dcd = 1'b0;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    check(txd === 1'b1, "R12 txd", txd, 1);
    check(tx_ready === 1'b1, "R12 tx_ready", tx_ready, 1);
    check(rx_valid === 1'b0, "R12 rx_valid", rx_valid, 0);
    check(lcr_rd === 8'h00, "R12 lcr_rd", lcr_rd, 0);
    check(mcr_rd === 8'h00, "R12 mcr_rd", mcr_rd, 0);
    model_on = 1;

    // R9 reserved bits read as zero
    tag = "R9";
    write_reg(1'b0, 8'hFF);
    write_reg(1'b1, 8'hEF);
    @(negedge clk);
    check(lcr_rd === 8'h07, "R9 lcr_rd", lcr_rd, 8'h07);
    check(mcr_rd === 8'h0F, "R9 mcr_rd", mcr_rd, 8'h0F);
    write_reg(1'b1, 8'h00);

    // R1 R2: 8 bits, single stop
    tag = "R1 R2";
    write_reg(1'b0, 8'h03);
    send(8'hA5); wait_tx_idle();
    // R1 R2: 7 bits, single stop, upper bit dropped
    write_reg(1'b0, 8'h02);
    send(8'hD5); wait_tx_idle();
    // R3: 5 bits with 1.5 stop, then 6 bits with 2 stop
    tag = "R3";
    write_reg(1'b0, 8'h04);
    send(8'h13); wait_tx_idle();
    write_reg(1'b0, 8'h05);
    send(8'h2A); wait_tx_idle();

    // R10: change format mid-character; R11: back-to-back handshake
    tag = "R10 R11";
    write_reg(1'b0, 8'h03);
    send(8'hC3);
    repeat (100) @(posedge clk);
    write_reg(1'b0, 8'h04);
    send(8'h1E);
    wait_tx_idle();

    // R7 R8: self-test mode, external rxd held low and ignored
    tag = "R7";
    rxd = 1'b0;
    dsr = 1'b0; cts = 1'b1; ri = 1'b0; dcd = 1'b1;
    write_reg(1'b1, 8'h15);
    write_reg(1'b0, 8'h07);
    @(negedge clk);
    check(dsr_st === 1'b1 && cts_st === 1'b0 && ri_st === 1'b1 && dcd_st === 1'b0,
          "R8 crossed status", {dsr_st, cts_st, ri_st, dcd_st}, 4'b1010);
    check(dtr === 1'b1 && rts === 1'b0 && out1 === 1'b1 && out2 === 1'b0,
          "R8 modem pins", {dtr, rts, out1, out2}, 4'b1010);
    send(8'h5A); wait_tx_idle();
    write_reg(1'b0, 8'h00);
    send(8'h1F); wait_tx_idle();
    repeat (200) @(posedge clk);
    rxd = 1'b1;
    repeat (8) @(posedge clk);
    write_reg(1'b1, 8'h0A);
    @(negedge clk);
    check(dsr_st === 1'b0 && cts_st === 1'b1 && ri_st === 1'b0 && dcd_st === 1'b1,
          "R8 pin status", {dsr_st, cts_st, ri_st, dcd_st}, 4'b0101);
    check(dtr === 1'b0 && rts === 1'b1 && out1 === 1'b0 && out2 === 1'b1,
          "R8 modem pins", {dtr, rts, out1, out2}, 4'b0101);
    check(exp_data.size() == 0, "R7 loopback characters all received", exp_data.size(), 0);

    // R4: external frames, 8 and 6 bits
    tag = "R4";
    write_reg(1'b0, 8'h03);
    drive_frame(8'h96, 8, 1'b1);
    hold_rx(1'b1, 20);
    write_reg(1'b0, 8'h01);
    drive_frame(8'h2D, 6, 1'b1);
    hold_rx(1'b1, 20);

    // R5: long stop configured, frames arrive with one stop each
    tag = "R5";
    write_reg(1'b0, 8'h07);
    drive_frame(8'h33, 8, 1'b1);
    drive_frame(8'hCC, 8, 1'b1);
    hold_rx(1'b1, 20);

    // R6: bad stop, line held low, then a good frame
    tag = "R6";
    drive_frame(8'h81, 8, 1'b0);
    hold_rx(1'b0, 40);
    hold_rx(1'b1, 20);
    drive_frame(8'h42, 8, 1'b1);
    hold_rx(1'b1, 20);

    repeat (50) @(posedge clk);
    @(negedge clk);
    check(exp_data.size() == 0, "R4 R5 R6 all expected characters seen", exp_data.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule